// File: doc/BRIEF.md
# Conditional Trap Evaluator

This unit decides whether a conditional trap instruction fires. It takes a first operand and a second operand. The second operand is either a register value or a 16-bit immediate, chosen by a form select. The immediate is always sign-extended to the data width, including for the unsigned conditions, which then compare the extended value as an unsigned number.

A 3-bit condition selector picks one of six relations:
- equal
- not equal
- signed greater-or-equal
- unsigned greater-or-equal
- signed less-than
- unsigned less-than

The decision is registered. On the cycle after an input strobe, the unit presents a one-cycle fire pulse and the exception code to pass on to the exception logic. The unit drives no architectural state. A trap therefore changes nothing except these outputs. Instruction decode and the exception entry sequence are handled elsewhere.

An unused selector value never fires. Instead, it raises a separate illegal-condition pulse on the same cycle timing.

Top module: `trap_eval`

## Requirements
- R1: While reset is active and on the first cycle after it, `fire`, `bad_cond` and `exc_code` are all zero.
- R2: Selector 3'd0 fires when the operands are equal. Selector 3'd1 fires when they differ.
- R3: Selector 3'd2 fires when `op_a` is greater than or equal to the second operand, both taken as two's-complement numbers. Selector 3'd4 fires when it is less.
- R4: Selector 3'd3 fires when `op_a` is greater than or equal to the second operand, both taken as unsigned numbers. Selector 3'd5 fires when it is less.
- R5: With `use_imm` high, the second operand is `imm` sign-extended to 32 bits for every selector. For example, 16'hFF9C becomes 32'hFFFFFF9C, even for selectors 3'd3 and 3'd5.
- R6: `fire` is high for exactly the one cycle after a cycle in which `in_valid` was high and the condition held. It is low in every other cycle.
- R7: `exc_code` equals 5'd13 in every cycle in which `fire` is high. It is 5'd0 in every other cycle.
- R8: Selectors 3'd6 and 3'd7 never fire. A strobe with either of them raises `bad_cond` for exactly the following cycle.
- R9: The operand that the form select does not choose has no effect. `imm` is ignored when `use_imm` is low, and `op_b` is ignored when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: evaluate the operands this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Register second operand |
| imm | input | 16 | Immediate second operand, sign-extended before use |
| use_imm | input | 1 | 1 selects the immediate form |
| cond_sel | input | 3 | Condition: 0 eq, 1 ne, 2 ge, 3 geu, 4 lt, 5 ltu, 6-7 unused |
| fire | output | 1 | Trap decision, registered one cycle after the strobe |
| exc_code | output | 5 | Exception code, 13 while firing and 0 otherwise |
| bad_cond | output | 1 | Strobe carried an unused selector value |

## Verification
The assertions relate each output to the strobe, selector and operands on the cycle before. They assume those inputs are known, not X, on every clock edge after reset, and they check nothing while reset is held.

The bench keeps every input at a defined value from time zero. It changes inputs only on falling edges and holds `in_valid` for exactly one cycle per evaluation, so each registered result lines up with a single cycle of sampled inputs. Back-to-back strobes are driven the same way, one fully defined input set per cycle.

// File: rtl/trap_eval.sv
module trap_eval #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int SEL_W     = 3,
  parameter int CODE_W    = 5,
  parameter int TRAP_CODE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [SEL_W-1:0]  cond_sel,
  output logic              fire,
  output logic [CODE_W-1:0] exc_code,
  output logic              bad_cond
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam logic [CODE_W-1:0] CODE_TRAP = CODE_W'(TRAP_CODE);
  localparam logic [SEL_W-1:0] C_EQ  = SEL_W'(0);
  localparam logic [SEL_W-1:0] C_NE  = SEL_W'(1);
  localparam logic [SEL_W-1:0] C_GE  = SEL_W'(2);
  localparam logic [SEL_W-1:0] C_GEU = SEL_W'(3);
  localparam logic [SEL_W-1:0] C_LT  = SEL_W'(4);
  localparam logic [SEL_W-1:0] C_LTU = SEL_W'(5);

  logic [DATA_W-1:0] rhs;
  logic              is_eq, is_slt, is_ult;
  logic              hit, legal;

  assign rhs    = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : op_b;
  assign is_eq  = (op_a == rhs);
  assign is_ult = (op_a < rhs);
  assign is_slt = ($signed(op_a) < $signed(rhs));

  always_comb begin
    hit   = 1'b0;
    legal = 1'b1;
    case (cond_sel)
      C_EQ:    hit = is_eq;
      C_NE:    hit = !is_eq;
      C_GE:    hit = !is_slt;
      C_GEU:   hit = !is_ult;
      C_LT:    hit = is_slt;
      C_LTU:   hit = is_ult;
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire     <= 1'b0;
      exc_code <= '0;
      bad_cond <= 1'b0;
    end else begin
      fire     <= in_valid && legal && hit;
      exc_code <= (in_valid && legal && hit) ? CODE_TRAP : '0;
      bad_cond <= in_valid && !legal;
    end
  end

endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk #(
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int CODE_W    = 5,
  parameter int TRAP_CODE = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              use_imm,
  input logic [SEL_W-1:0]  cond_sel,
  input logic              fire,
  input logic [CODE_W-1:0] exc_code,
  input logic              bad_cond
);

  AST_FIRE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(in_valid)); // R6

  AST_CODE_WHILE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> exc_code == CODE_W'(TRAP_CODE)); // R7

  AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> exc_code == '0); // R7

  AST_BAD_NEVER_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && bad_cond)); // R8

  AST_BAD_FROM_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cond |-> ($past(in_valid) && $past(cond_sel) >= SEL_W'(6))); // R8

  AST_UNUSED_SEL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel >= SEL_W'(6)) |=> bad_cond); // R8

  AST_EQ_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_imm && cond_sel == '0) |=> fire == ($past(op_a) == $past(op_b))); // R2

endmodule

bind trap_eval trap_eval_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .use_imm(use_imm), .cond_sel(cond_sel), .fire(fire), .exc_code(exc_code),
  .bad_cond(bad_cond)
);

// File: tb/trap_eval_tb.sv
module trap_eval_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic        fire;
  logic [4:0]  exc_code;
  logic        bad_cond;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_eval u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .imm(imm), .use_imm(use_imm), .cond_sel(cond_sel), .fire(fire),
    .exc_code(exc_code), .bad_cond(bad_cond)
  );

  // {use_imm, cond_sel, op_a, op_b, imm, expected fire}
  localparam int NV = 16;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 3'd0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b1}, // R2 eq
    {1'b0, 3'd0, 32'h0000_0005, 32'h0000_0006, 16'h0000, 1'b0}, // R2 eq miss
    {1'b0, 3'd1, 32'h0000_0005, 32'h0000_0006, 16'h0000, 1'b1}, // R2 ne
    {1'b0, 3'd1, 32'h0000_0007, 32'h0000_0007, 16'h0000, 1'b0}, // R2 ne miss
    {1'b0, 3'd2, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0}, // R3 -1 >= 1
    {1'b0, 3'd3, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b1}, // R4 unsigned
    {1'b0, 3'd4, 32'h8000_0000, 32'h0000_0000, 16'h0000, 1'b1}, // R3 lt
    {1'b0, 3'd5, 32'h8000_0000, 32'h0000_0000, 16'h0000, 1'b0}, // R4 ltu
    {1'b0, 3'd2, 32'h0000_0003, 32'h0000_0003, 16'h0000, 1'b1}, // R3 equal edge
    {1'b1, 3'd5, 32'hFFFF_FF00, 32'h0000_0000, 16'hFF9C, 1'b1}, // R5 ltu imm
    {1'b1, 3'd3, 32'h0000_FFFF, 32'hFFFF_FFFF, 16'hFF9C, 1'b0}, // R5 geu imm
    {1'b1, 3'd4, 32'hFFFF_FF9B, 32'h0000_0000, 16'hFF9C, 1'b1}, // R5 lt imm
    {1'b1, 3'd0, 32'hFFFF_FF9C, 32'h1234_5678, 16'hFF9C, 1'b1}, // R9 op_b ignored
    {1'b0, 3'd0, 32'h0000_0001, 32'h0000_0001, 16'hABCD, 1'b1}, // R9 imm ignored
    {1'b1, 3'd2, 32'h0000_0000, 32'h0000_0000, 16'h8000, 1'b1}, // R5 ge imm
    {1'b1, 3'd1, 32'h0000_FF9C, 32'h0000_FF9C, 16'hFF9C, 1'b1}  // R5 not zero-ext
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ui, input logic [2:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i, input logic v);
    use_imm = ui; cond_sel = c; op_a = a; op_b = b; imm = i; in_valid = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    drive(1'b0, 3'd0, 32'd1, 32'd1, 16'd0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R1 fire in reset", {31'd0, fire}, 32'd0);
    chk("R1 code in reset", {27'd0, exc_code}, 32'd0);
    chk("R1 bad in reset", {31'd0, bad_cond}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fire after reset", {31'd0, fire}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][84], VEC[k][83:81], VEC[k][80:49], VEC[k][48:17], VEC[k][16:1], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R2-R5/R9 vec%0d fire", k), {31'd0, fire}, {31'd0, VEC[k][0]});
      chk($sformatf("R7 vec%0d code", k), {27'd0, exc_code}, VEC[k][0] ? 32'd13 : 32'd0);
      chk($sformatf("R8 vec%0d bad", k), {31'd0, bad_cond}, 32'd0);
    end

    // R6: true condition without strobe does not fire; pulse lasts one cycle
    drive(1'b0, 3'd0, 32'd9, 32'd9, 16'd0, 1'b0);
    @(negedge clk);
    chk("R6 no strobe", {31'd0, fire}, 32'd0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 pulse", {31'd0, fire}, 32'd1);
    @(negedge clk);
    chk("R6 pulse ends", {31'd0, fire}, 32'd0);
    chk("R7 code cleared", {27'd0, exc_code}, 32'd0);

    // R6: back-to-back strobes, hit then miss
    drive(1'b0, 3'd1, 32'd1, 32'd2, 16'd0, 1'b1);
    @(negedge clk);
    chk("R6 b2b first", {31'd0, fire}, 32'd1);
    drive(1'b0, 3'd1, 32'd2, 32'd2, 16'd0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 b2b second", {31'd0, fire}, 32'd0);

    // R8: unused selectors with operands that would satisfy any relation test
    for (int s = 6; s < 8; s++) begin
      drive(1'b0, 3'(s), 32'd4, 32'd4, 16'd0, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 sel%0d fire", s), {31'd0, fire}, 32'd0);
      chk($sformatf("R8 sel%0d bad", s), {31'd0, bad_cond}, 32'd1);
      chk($sformatf("R8 sel%0d code", s), {27'd0, exc_code}, 32'd0);
      @(negedge clk);
      chk($sformatf("R8 sel%0d bad clears", s), {31'd0, bad_cond}, 32'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule